// File: doc/BRIEF.md
# Static Memory Bus Timing Sequencer

This block turns single requests from on-chip logic into strobe waveforms for an asynchronous external memory bus. A request carries an address, write data, byte enables, a direction flag and a chip-select index. Once it accepts a request, the block drives the address for a whole bus cycle. It places the active-low chip select, the read strobe or the write strobe, and the byte selects in windows timed in clock counts from the start of that cycle.

Timing comes from compressed codes on static input ports. Read and write accesses each have their own total-cycle code. The read strobe, the write strobe and the chip select in each direction each have their own setup and pulse codes. Hold time is whatever remains of the cycle after setup and pulse. The codes are non-linear: a high-order bit adds a large fixed offset to a small linear field, so one narrow field covers both short and very long devices.

The block accepts the next request during the final clock of the current cycle. When the next request targets a different chip select, it inserts one clock with every bus control high before the new cycle starts. Read data is captured as the read strobe rises and is returned with a one-clock done pulse.

Top module: `smc_seq`

## Requirements
- R1: The strobe of the access direction goes low after S clocks, counted from the first clock of the access (clock 0). S is 128 × code[5] + code[4:0] of the 6-bit setup code for that strobe.
- R2: The strobe stays low for P consecutive clocks. P is 256 × code[6] + code[5:0] of its 7-bit pulse code.
- R3: An access lasts C clocks. C is 256 × code[8:7] + code[6:0] of the 9-bit cycle code for the direction. `reqReady` is low from acceptance until the last of these C clocks, and is high in that last clock.
- R4: The chip select uses its own setup and pulse codes, separately for reads and for writes. Codes of the other direction have no effect on an access. The strobe of the other direction stays high throughout.
- R5: `memAddr` holds the accepted address for every clock of the access. `memBsN` equals the inverted byte enables (bit i low means byte lane i selected) for every clock of the access.
- R6: At most one `memCsN` bit is low at a time. It is bit `reqCs` of the accepted request, with bit 0 for index 0.
- R7: A request accepted in the final clock of an access that targets a different chip select is followed by exactly one clock in which every chip select, both strobes and all byte selects are high. The new access starts after that clock. With the same chip select, the new access starts on the next clock.
- R8: On a read, `memDataIn` is captured at the clock edge where `memRdN` returns high. That value appears on `rdData` while `rdDone` is high for one clock directly after that edge.
- R9: `memDataOe` is high for every clock of a write access, carrying the write data on `memDataOut`. It is low otherwise, including during reads.
- R10: With an illegal timing setting (zero pulse, or setup plus pulse beyond the cycle), the access still ends after C clocks. A cycle code of 0 gives a one-clock access.
- R11: After reset `reqReady` is high, all chip selects, strobes and byte selects are high, and `memDataOe` and `rdDone` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be taken this clock |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqCs | input | 3 | Chip-select index, 0 to 5 |
| reqAddr | input | 24 | Access address |
| reqWdata | input | 16 | Write data |
| reqBe | input | 2 | Byte enables, bit i = lane i |
| rdSetupCode | input | 6 | Read strobe setup code |
| rdPulseCode | input | 7 | Read strobe pulse code |
| csRdSetupCode | input | 6 | Chip select setup code on reads |
| csRdPulseCode | input | 7 | Chip select pulse code on reads |
| rdCycleCode | input | 9 | Read cycle length code |
| wrSetupCode | input | 6 | Write strobe setup code |
| wrPulseCode | input | 7 | Write strobe pulse code |
| csWrSetupCode | input | 6 | Chip select setup code on writes |
| csWrPulseCode | input | 7 | Chip select pulse code on writes |
| wrCycleCode | input | 9 | Write cycle length code |
| memAddr | output | 24 | External address bus |
| memCsN | output | 6 | Active-low chip selects |
| memRdN | output | 1 | Active-low read strobe |
| memWeN | output | 1 | Active-low write strobe |
| memBsN | output | 2 | Active-low byte selects |
| memDataOut | output | 16 | Data driven to the bus |
| memDataOe | output | 1 | Data bus output enable |
| memDataIn | input | 16 | Data read from the bus |
| rdData | output | 16 | Captured read data |
| rdDone | output | 1 | One-clock read completion pulse |

## Verification
Every cycle, the assertions check these properties:
- Whenever no access is in progress, the bus is quiet.
- Chip selects stay one-hot or idle.
- The address holds inside an access.
- The output enable never coincides with a read strobe.
- A done pulse always follows a low read strobe.
- The counter stays within the largest legal cycle.
- A gap clock leads straight into a new access.

Some behaviour only the bench scenarios can show:
- That the decoded setup, pulse and cycle counts match the non-linear codes, including the 128, 256, 512 and 768 offsets.
- That the other direction's codes are ignored.
- That the idle clock appears only on a chip-select change.
- That illegal settings still end on time.

// File: rtl/smc_seq_pkg.sv
package smc_seq_pkg;

  // width of any decoded clock count (largest is 3*256+127)
  localparam int TW = 10;

  // control-to-datapath strobes for one clock
  typedef struct packed {
    logic load;     // request accepted at the coming edge
    logic busy;     // an access clock is in progress
    logic csOn;     // chip select window
    logic rdOn;     // read strobe window
    logic wrOn;     // write strobe window
    logic capture;  // read strobe ends at the coming edge
  } smcStrobeT;

  function automatic logic [TW-1:0] decodeSetup(input logic [5:0] code);
    return TW'({code[5], 7'b0}) + TW'(code[4:0]);
  endfunction

  function automatic logic [TW-1:0] decodePulse(input logic [6:0] code);
    return TW'({code[6], 8'b0}) + TW'(code[5:0]);
  endfunction

  function automatic logic [TW-1:0] decodeCycle(input logic [8:0] code);
    return TW'({code[8:7], 8'b0}) + TW'(code[6:0]);
  endfunction

  function automatic logic inWindow(input logic [TW-1:0] cnt,
                                    input logic [TW-1:0] start,
                                    input logic [TW-1:0] len);
    return (cnt >= start) && ({1'b0, cnt} < ({1'b0, start} + {1'b0, len}));
  endfunction

endpackage

// File: rtl/smc_seq_ctrl.sv
module smc_seq_ctrl
  import smc_seq_pkg::*;
#(
  parameter int CS_W = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic [CS_W-1:0] reqCs,
  output logic            reqReady,
  input  logic            curWrite,
  input  logic [CS_W-1:0] curCs,
  input  logic [5:0]      rdSetupCode,
  input  logic [6:0]      rdPulseCode,
  input  logic [5:0]      csRdSetupCode,
  input  logic [6:0]      csRdPulseCode,
  input  logic [8:0]      rdCycleCode,
  input  logic [5:0]      wrSetupCode,
  input  logic [6:0]      wrPulseCode,
  input  logic [5:0]      csWrSetupCode,
  input  logic [6:0]      csWrPulseCode,
  input  logic [8:0]      wrCycleCode,
  output smcStrobeT       stb
);

  localparam logic [TW-1:0] MAX_CNT = TW'(3 * 256 + 127);

  typedef enum logic [1:0] {S_IDLE, S_GAP, S_ACC} stateT;

  stateT         state;
  logic [TW-1:0] cnt;
  logic [TW-1:0] stpD, pulD, csStpD, csPulD, cycD;
  logic [TW:0]   cntNext;
  logic          lastClk, accept, needGap, rdWin, wrWin;

  always_comb begin
    if (curWrite) begin
      stpD   = decodeSetup(wrSetupCode);
      pulD   = decodePulse(wrPulseCode);
      csStpD = decodeSetup(csWrSetupCode);
      csPulD = decodePulse(csWrPulseCode);
      cycD   = decodeCycle(wrCycleCode);
    end else begin
      stpD   = decodeSetup(rdSetupCode);
      pulD   = decodePulse(rdPulseCode);
      csStpD = decodeSetup(csRdSetupCode);
      csPulD = decodePulse(csRdPulseCode);
      cycD   = decodeCycle(rdCycleCode);
    end
  end

  assign cntNext  = {1'b0, cnt} + 1'b1;
  assign lastClk  = (state == S_ACC) && (cntNext >= {1'b0, cycD});
  assign reqReady = (state == S_IDLE) || lastClk;
  assign accept   = reqValid && reqReady;
  assign needGap  = lastClk && (reqCs != curCs);

  assign rdWin = (state == S_ACC) && !curWrite && inWindow(cnt, stpD, pulD);
  assign wrWin = (state == S_ACC) && curWrite && inWindow(cnt, stpD, pulD);

  always_comb begin
    stb.load    = accept;
    stb.busy    = (state == S_ACC);
    stb.csOn    = (state == S_ACC) && inWindow(cnt, csStpD, csPulD);
    stb.rdOn    = rdWin;
    stb.wrOn    = wrWin;
    stb.capture = rdWin && (cntNext == ({1'b0, stpD} + {1'b0, pulD}));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (accept) begin
          state <= S_ACC;
          cnt   <= '0;
        end
        S_GAP: begin
          state <= S_ACC;
          cnt   <= '0;
        end
        default: begin
          if (lastClk) begin
            cnt <= '0;
            if (accept) state <= needGap ? S_GAP : S_ACC;
            else        state <= S_IDLE;
          end else begin
            cnt <= cntNext[TW-1:0];
          end
        end
      endcase
    end
  end

  // R10
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ACC) |-> (cnt <= MAX_CNT));

  // R7
  gap_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_GAP) |=> (state == S_ACC) && (cnt == '0));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == S_ACC) && !lastClk) |=> (state == S_ACC) && (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/smc_seq_dp.sv
module smc_seq_dp
  import smc_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int NUM_CS = 6,
  parameter int CS_W   = 3,
  parameter int BE_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  smcStrobeT         stb,
  input  logic              reqWrite,
  input  logic [CS_W-1:0]   reqCs,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [BE_W-1:0]   reqBe,
  output logic              curWrite,
  output logic [CS_W-1:0]   curCs,
  output logic [ADDR_W-1:0] memAddr,
  output logic [NUM_CS-1:0] memCsN,
  output logic              memRdN,
  output logic              memWeN,
  output logic [BE_W-1:0]   memBsN,
  output logic [DATA_W-1:0] memDataOut,
  output logic              memDataOe,
  input  logic [DATA_W-1:0] memDataIn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDone
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [BE_W-1:0]   beQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      dataQ    <= '0;
      beQ      <= '0;
      curWrite <= 1'b0;
      curCs    <= '0;
      rdData   <= '0;
      rdDone   <= 1'b0;
    end else begin
      if (stb.load) begin
        addrQ    <= reqAddr;
        dataQ    <= reqWdata;
        beQ      <= reqBe;
        curWrite <= reqWrite;
        curCs    <= reqCs;
      end
      rdDone <= stb.capture;
      if (stb.capture) rdData <= memDataIn;
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : gCsDrive
    assign memCsN[i] = !(stb.csOn && (curCs == CS_W'(i)));
  end

  assign memAddr    = addrQ;
  assign memRdN     = !stb.rdOn;
  assign memWeN     = !stb.wrOn;
  assign memBsN     = stb.busy ? ~beQ : '1;
  assign memDataOut = dataQ;
  assign memDataOe  = stb.busy && curWrite;

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.busy |-> ((&memCsN) && memRdN && memWeN && (&memBsN) && !memDataOe));

  // R6
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~memCsN));

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.busy && $past(stb.busy) && !$past(stb.load)) |-> $stable(memAddr));

  // R8
  done_after_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdDone |-> $past(!memRdN));

  // R9
  oe_not_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    memDataOe |-> memRdN);

endmodule

// File: rtl/smc_seq.sv
module smc_seq
  import smc_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int NUM_CS = 6,
  localparam int CS_W  = $clog2(NUM_CS),
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [CS_W-1:0]   reqCs,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [BE_W-1:0]   reqBe,
  input  logic [5:0]        rdSetupCode,
  input  logic [6:0]        rdPulseCode,
  input  logic [5:0]        csRdSetupCode,
  input  logic [6:0]        csRdPulseCode,
  input  logic [8:0]        rdCycleCode,
  input  logic [5:0]        wrSetupCode,
  input  logic [6:0]        wrPulseCode,
  input  logic [5:0]        csWrSetupCode,
  input  logic [6:0]        csWrPulseCode,
  input  logic [8:0]        wrCycleCode,
  output logic [ADDR_W-1:0] memAddr,
  output logic [NUM_CS-1:0] memCsN,
  output logic              memRdN,
  output logic              memWeN,
  output logic [BE_W-1:0]   memBsN,
  output logic [DATA_W-1:0] memDataOut,
  output logic              memDataOe,
  input  logic [DATA_W-1:0] memDataIn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDone
);

  smcStrobeT       stb;
  logic            curWrite;
  logic [CS_W-1:0] curCs;

  smc_seq_ctrl #(.CS_W(CS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCs(reqCs), .reqReady(reqReady),
    .curWrite(curWrite), .curCs(curCs),
    .rdSetupCode(rdSetupCode), .rdPulseCode(rdPulseCode),
    .csRdSetupCode(csRdSetupCode), .csRdPulseCode(csRdPulseCode), .rdCycleCode(rdCycleCode),
    .wrSetupCode(wrSetupCode), .wrPulseCode(wrPulseCode),
    .csWrSetupCode(csWrSetupCode), .csWrPulseCode(csWrPulseCode), .wrCycleCode(wrCycleCode),
    .stb(stb)
  );

  smc_seq_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CS(NUM_CS), .CS_W(CS_W), .BE_W(BE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .reqWrite(reqWrite), .reqCs(reqCs), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe),
    .curWrite(curWrite), .curCs(curCs),
    .memAddr(memAddr), .memCsN(memCsN), .memRdN(memRdN), .memWeN(memWeN), .memBsN(memBsN),
    .memDataOut(memDataOut), .memDataOe(memDataOe), .memDataIn(memDataIn),
    .rdData(rdData), .rdDone(rdDone)
  );

endmodule

// File: tb/smc_seq_bench.sv
`timescale 1ns/1ps
module smc_seq_bench;

  localparam int AW = 24;
  localparam int DW = 16;
  localparam int NC = 6;
  localparam int CW = 3;
  localparam int BW = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0, reqWrite = 1'b0;
  logic [CW-1:0] reqCs = '0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic [BW-1:0] reqBe = '0;
  logic [5:0]    rdSetupCode = '0, csRdSetupCode = '0, wrSetupCode = '0, csWrSetupCode = '0;
  logic [6:0]    rdPulseCode = '0, csRdPulseCode = '0, wrPulseCode = '0, csWrPulseCode = '0;
  logic [8:0]    rdCycleCode = '0, wrCycleCode = '0;
  logic [DW-1:0] memDataIn = '0;
  logic          reqReady, memRdN, memWeN, memDataOe, rdDone;
  logic [AW-1:0] memAddr;
  logic [NC-1:0] memCsN;
  logic [BW-1:0] memBsN;
  logic [DW-1:0] memDataOut, rdData;

  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  smc_seq u_smc_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqCs(reqCs), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe),
    .rdSetupCode(rdSetupCode), .rdPulseCode(rdPulseCode), .csRdSetupCode(csRdSetupCode),
    .csRdPulseCode(csRdPulseCode), .rdCycleCode(rdCycleCode),
    .wrSetupCode(wrSetupCode), .wrPulseCode(wrPulseCode), .csWrSetupCode(csWrSetupCode),
    .csWrPulseCode(csWrPulseCode), .wrCycleCode(wrCycleCode),
    .memAddr(memAddr), .memCsN(memCsN), .memRdN(memRdN), .memWeN(memWeN), .memBsN(memBsN),
    .memDataOut(memDataOut), .memDataOe(memDataOe), .memDataIn(memDataIn),
    .rdData(rdData), .rdDone(rdDone)
  );

  typedef struct packed {
    logic       wr;
    logic [2:0] cs;
    logic [5:0] su;
    logic [6:0] pu;
    logic [5:0] csSu;
    logic [6:0] csPu;
    logic [8:0] cyc;
  } vecT;

  typedef struct {
    int len, stFirst, stCnt, csFirst, csCnt, oeCnt, otherLow;
    int addrBad, bsBad, dataBad, csBad, doneAt;
  } measT;

  localparam int NVEC = 6;
  localparam vecT VEC [NVEC] = '{
    '{1'b0, 3'd0, 6'd2,        7'd3,        6'd1,  7'd5,        9'd8},
    '{1'b1, 3'd1, 6'd1,        7'd4,        6'd0,  7'd6,        9'd7},
    '{1'b0, 3'd2, 6'b100001,   7'd2,        6'd0,  7'b1000000,  9'b010000010},
    '{1'b1, 3'd5, 6'd3,        7'b1000010,  6'd0,  7'b1000101,  9'b100000101},
    '{1'b0, 3'd3, 6'd0,        7'd1,        6'd0,  7'd1,        9'b110000000},
    '{1'b1, 3'd4, 6'd31,       7'd63,       6'd31, 7'd63,       9'd127}
  };

  function automatic int expSetup(input logic [5:0] c);
    return (c[5] ? 128 : 0) + int'(c[4:0]);
  endfunction
  function automatic int expPulse(input logic [6:0] c);
    return (c[6] ? 256 : 0) + int'(c[5:0]);
  endfunction
  function automatic int expCycle(input logic [8:0] c);
    return int'(c[8:7]) * 256 + int'(c[6:0]);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // codes for the selected direction; the other direction gets unrelated values
  task automatic setTiming(input vecT v);
    if (v.wr) begin
      wrSetupCode = v.su; wrPulseCode = v.pu; csWrSetupCode = v.csSu;
      csWrPulseCode = v.csPu; wrCycleCode = v.cyc;
      rdSetupCode = 6'd9; rdPulseCode = 7'd2; csRdSetupCode = 6'd3;
      csRdPulseCode = 7'd1; rdCycleCode = 9'd20;
    end else begin
      rdSetupCode = v.su; rdPulseCode = v.pu; csRdSetupCode = v.csSu;
      csRdPulseCode = v.csPu; rdCycleCode = v.cyc;
      wrSetupCode = 6'd9; wrPulseCode = 7'd2; csWrSetupCode = 6'd3;
      csWrPulseCode = 7'd1; wrCycleCode = 9'd20;
    end
  endtask

  task automatic runOne(input vecT v, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [BW-1:0] be, output measT m);
    logic [NC-1:0] csMask;
    csMask = ~(NC'(1) << v.cs);
    m = '{default: 0};
    m.stFirst = -1; m.csFirst = -1; m.doneAt = -1; m.len = -1;
    @(negedge clk);
    setTiming(v);
    reqValid = 1'b1; reqWrite = v.wr; reqCs = v.cs; reqAddr = a; reqWdata = d; reqBe = be;
    memDataIn = d ^ 16'hA5A5;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    for (int k = 0; k < 2000; k++) begin
      if (k > 0) @(negedge clk);
      if (v.wr ? !memWeN : !memRdN) begin
        if (m.stFirst < 0) m.stFirst = k;
        m.stCnt++;
      end
      if (v.wr ? !memRdN : !memWeN) m.otherLow++;
      if (memCsN != '1) begin
        if (memCsN != csMask) m.csBad++;
        if (m.csFirst < 0) m.csFirst = k;
        m.csCnt++;
      end
      if (memDataOe) m.oeCnt++;
      if (memAddr != a) m.addrBad++;
      if (memBsN != ~be) m.bsBad++;
      if (memDataOe && memDataOut != d) m.dataBad++;
      if (rdDone && m.doneAt < 0) m.doneAt = k;
      if (reqReady) begin
        m.len = k + 1;
        break;
      end
    end
    repeat (2) @(negedge clk);
  endtask

  // two accesses: the second is offered during the first and taken in its final clock
  task automatic backToBack(input logic [2:0] cs2, input bit expectGap);
    vecT v;
    v = '{1'b0, 3'd0, 6'd0, 7'd2, 6'd0, 7'd3, 9'd4};
    @(negedge clk);
    setTiming(v);
    reqValid = 1'b1; reqWrite = 1'b0; reqCs = 3'd0; reqAddr = 24'h000AA0; reqBe = 2'b11;
    @(posedge clk);
    @(negedge clk);
    reqCs = cs2; reqAddr = 24'h000BB0;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    if (expectGap) begin
      // R7 one all-inactive clock on a chip-select change
      chk("R7 gap controls high", int'((&memCsN) && memRdN && memWeN && (&memBsN)), 1);
      chk("R7 ready low in gap", int'(reqReady), 0);
      @(negedge clk);
    end
    // R7 new access under way, chip select of the new index low
    chk("R7 new chip select low", int'(memCsN[cs2]), 0);
    chk("R7 new address driven", int'(memAddr == 24'h000BB0), 1);
    while (!reqReady) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual expired expected finish");
    finishRun();
  end

  initial begin
    measT m;
    vecT v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 ready", int'(reqReady), 1);
    chk("R11 controls high", int'((&memCsN) && memRdN && memWeN && (&memBsN)), 1);
    chk("R11 oe and done low", int'(memDataOe || rdDone), 0);

    for (int i = 0; i < NVEC; i++) begin
      runOne(VEC[i], 24'h100000 + AW'(i * 16), 16'h1234 + DW'(i),
             i[0] ? 2'b01 : 2'b11, m);
      chk("R1 strobe setup", m.stFirst, expSetup(VEC[i].su));
      chk("R2 strobe pulse", m.stCnt, expPulse(VEC[i].pu));
      chk("R3 cycle length", m.len, expCycle(VEC[i].cyc));
      chk("R4 chip select setup", m.csFirst, expSetup(VEC[i].csSu));
      chk("R4 chip select pulse", m.csCnt, expPulse(VEC[i].csPu));
      chk("R4 other strobe quiet", m.otherLow, 0);
      chk("R5 address held", m.addrBad, 0);
      chk("R5 byte selects", m.bsBad, 0);
      chk("R6 chip select index", m.csBad, 0);
      chk("R9 oe clocks", m.oeCnt, VEC[i].wr ? m.len : 0);
      chk("R9 write data", m.dataBad, 0);
      if (!VEC[i].wr) begin
        chk("R8 done clock", m.doneAt, expSetup(VEC[i].su) + expPulse(VEC[i].pu));
        chk("R8 read data", int'(rdData), int'((16'h1234 + DW'(i)) ^ 16'hA5A5));
      end else begin
        chk("R8 no done on write", m.doneAt, -1);
      end
    end

    backToBack(3'd1, 1'b1);
    backToBack(3'd0, 1'b0);

    // R10 zero pulse still ends after the cycle count
    v = '{1'b0, 3'd2, 6'd5, 7'd0, 6'd0, 7'd1, 9'd3};
    runOne(v, 24'h0C0000, 16'h0, 2'b11, m);
    chk("R10 zero pulse length", m.len, 3);
    // R10 setup plus pulse past the cycle
    v = '{1'b1, 3'd2, 6'd2, 7'd6, 6'd0, 7'd9, 9'd4};
    runOne(v, 24'h0C0010, 16'h0, 2'b11, m);
    chk("R10 overlong window length", m.len, 4);
    // R10 cycle code zero gives a single clock
    v = '{1'b0, 3'd1, 6'd0, 7'd1, 6'd0, 7'd1, 9'd0};
    runOne(v, 24'h0C0020, 16'h0, 2'b11, m);
    chk("R10 zero cycle length", m.len, 1);
    chk("R10 ready after", int'(reqReady), 1);

    finishRun();
  end

endmodule